// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This datapath treats its operand vectors as a set of independent 32-bit lanes. For every lane it takes the four bytes of the first operand and the four bytes of the second operand that sit in that lane. It multiplies the bytes in pairs, adds the four products to the lane's 32-bit accumulator word, and puts the 32-bit sum on the output. A 3-bit mode input sets two things. Its low field chooses how the bytes are extended before multiplying: both signed, first signed with second unsigned, or both unsigned. Its top bit chooses whether the lane sum wraps or clamps. In clamping mode the bound is the signed 32-bit range when any operand is signed, and the unsigned 32-bit range when both operands are unsigned.

`VEC_W` sets the active vector width to 128 bits (4 lanes) or 256 bits (8 lanes). The output port is always `MAX_W` bits wide, and every bit above `VEC_W` reads as zero. When `OUT_REG` is 1, a result register captures the lane sums on each cycle that has a valid input, and the matching valid output rises one cycle later. When `OUT_REG` is 0, the result and valid pass straight through with no register. The block keeps no state apart from that register: a sync-reset "idle/holding" pair, where reset gives idle, an accepted input moves to holding, and a cycle with no input returns valid to low while the data is kept.

Top module: `bdot_accum`

## Requirements
- R1: Output lane j (bits 32j+31..32j) depends only on accumulator lane j and on bytes 4j..4j+3 of each operand, with byte 4j+k paired with byte 4j+k. Byte 4j+k sits at bits 32j+8k+7..32j+8k.
- R2: When mode[1:0] = 00, both operands' bytes are sign-extended before multiplying, and the accumulator is sign-extended.
- R3: When mode[1:0] = 01, first-operand bytes are sign-extended, second-operand bytes are zero-extended, and each product is a signed value.
- R4: When mode[1:0] = 10, both operands' bytes and the accumulator are zero-extended.
- R5: When mode[2] = 0, each lane returns (accumulator + four products) modulo 2^32.
- R6: When mode[2] = 1 and mode[1:0] is 00 or 01, the exact lane sum is clamped to 0x80000000..0x7FFFFFFF.
- R7: When mode[2] = 1 and mode[1:0] = 10, the exact lane sum is clamped to at most 0xFFFFFFFF.
- R8: When mode[1:0] = 11 (reserved), every output lane is zero, whatever mode[2] is.
- R9: Output bits at and above VEC_W are always zero.
- R10: With OUT_REG = 1, a synchronous active-high reset clears out_valid and the result. A cycle with in_valid high puts its result and out_valid = 1 on the output one clock later. A cycle with in_valid low drops out_valid and leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs hold a new operation this cycle |
| mode | input | 3 | [1:0] extension select (00 ss, 01 su, 10 uu, 11 reserved); [2] clamp enable |
| acc_in | input | VEC_W | Packed 32-bit accumulator lanes |
| a_in | input | VEC_W | First byte operand vector |
| b_in | input | VEC_W | Second byte operand vector |
| out_valid | output | 1 | Result holds a new value |
| result | output | MAX_W | Packed 32-bit results, zero above VEC_W |

## Verification
The assertions check on every evaluation that the clamp stage keeps the sign of the exact sum when signed clamping is on. They also check that unsigned clamping never returns less than the wrapped value, that reserved modes give zero lanes, that the upper output bits stay zero, and that the register's valid and hold behaviour holds cycle by cycle. Only the bench's scenarios show that the arithmetic is correct. These scenarios cover -128 × -128 in every pair, 255 × 255 with the largest accumulator, overflow in both signed directions, mixed-sign products, lane independence, and a randomized sweep across all modes, all compared lane by lane against a behavioural model.

// File: rtl/bdot_pkg.sv
package bdot_pkg;
    localparam int LANE_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int PAIRS   = LANE_W / BYTE_W;
    localparam int XBYTE_W = BYTE_W + 1;
    localparam int PROD_W  = 2 * XBYTE_W;
    localparam int SUM_W   = LANE_W + 2;

    typedef enum logic [1:0] {
        EXT_SS  = 2'b00,
        EXT_SU  = 2'b01,
        EXT_UU  = 2'b10,
        EXT_RSV = 2'b11
    } ext_mode_e;

    typedef struct packed {
        logic a_sgn;
        logic b_sgn;
        logic acc_sgn;
        logic clamp;
        logic uns_clamp;
        logic zero_out;
    } lane_ctl_t;
endpackage

// File: rtl/bdot_sat.sv
module bdot_sat
    import bdot_pkg::*;
(
    input  logic signed [SUM_W-1:0] sum_i,
    input  lane_ctl_t               ctl_i,
    output logic [LANE_W-1:0]       y_o
);
    localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'(64'sh7FFF_FFFF);
    localparam logic signed [SUM_W-1:0] S_MIN = SUM_W'(-64'sh8000_0000);

    always_comb begin
        if (ctl_i.zero_out) begin
            y_o = '0;
        end else if (!ctl_i.clamp) begin
            y_o = sum_i[LANE_W-1:0];
        end else if (ctl_i.uns_clamp) begin
            y_o = (sum_i[SUM_W-1:LANE_W] != '0) ? '1 : sum_i[LANE_W-1:0];
        end else if (sum_i > S_MAX) begin
            y_o = {1'b0, {(LANE_W-1){1'b1}}};
        end else if (sum_i < S_MIN) begin
            y_o = {1'b1, {(LANE_W-1){1'b0}}};
        end else begin
            y_o = sum_i[LANE_W-1:0];
        end
    end

    always_comb begin
        if (!ctl_i.zero_out && ctl_i.clamp && !ctl_i.uns_clamp) begin
            // R6
            signed_sign_chk: assert (y_o[LANE_W-1] == sum_i[SUM_W-1]);
        end
        if (!ctl_i.zero_out && ctl_i.clamp && ctl_i.uns_clamp) begin
            // R7
            uns_floor_chk: assert (y_o >= sum_i[LANE_W-1:0]);
        end
        if (ctl_i.zero_out) begin
            // R8
            rsv_zero_chk: assert (y_o == '0);
        end
    end
endmodule

// File: rtl/bdot_lane.sv
module bdot_lane
    import bdot_pkg::*;
(
    input  lane_ctl_t         ctl_i,
    input  logic [LANE_W-1:0] acc_i,
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    output logic [LANE_W-1:0] y_o
);
    logic signed [PROD_W-1:0] prod [PAIRS];
    logic signed [SUM_W-1:0]  acc_x;
    logic signed [SUM_W-1:0]  total;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        logic signed [XBYTE_W-1:0] a_x;
        logic signed [XBYTE_W-1:0] b_x;
        assign a_x = {ctl_i.a_sgn & a_i[BYTE_W*k+BYTE_W-1], a_i[BYTE_W*k +: BYTE_W]};
        assign b_x = {ctl_i.b_sgn & b_i[BYTE_W*k+BYTE_W-1], b_i[BYTE_W*k +: BYTE_W]};
        assign prod[k] = a_x * b_x;
    end

    assign acc_x = {{(SUM_W-LANE_W){ctl_i.acc_sgn & acc_i[LANE_W-1]}}, acc_i};

    always_comb begin
        total = acc_x;
        for (int k = 0; k < PAIRS; k++) begin
            total = total + SUM_W'(prod[k]);
        end
    end

    bdot_sat u_sat (
        .sum_i (total),
        .ctl_i (ctl_i),
        .y_o   (y_o)
    );
endmodule

// File: rtl/bdot_accum.sv
module bdot_accum
    import bdot_pkg::*;
#(
    parameter int MAX_W   = 256,
    parameter int VEC_W   = 256,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       mode,
    input  logic [VEC_W-1:0] acc_in,
    input  logic [VEC_W-1:0] a_in,
    input  logic [VEC_W-1:0] b_in,
    output logic             out_valid,
    output logic [MAX_W-1:0] result
);
    localparam int LANES = VEC_W / LANE_W;

    ext_mode_e        ext;
    lane_ctl_t        ctl;
    logic [VEC_W-1:0] lane_res;

    assign ext = ext_mode_e'(mode[1:0]);

    always_comb begin
        ctl = '0;
        ctl.clamp = mode[2];
        unique case (ext)
            EXT_SS: begin
                ctl.a_sgn = 1'b1; ctl.b_sgn = 1'b1; ctl.acc_sgn = 1'b1;
            end
            EXT_SU: begin
                ctl.a_sgn = 1'b1; ctl.acc_sgn = 1'b1;
            end
            EXT_UU: begin
                ctl.uns_clamp = 1'b1;
            end
            EXT_RSV: begin
                ctl.zero_out = 1'b1;
            end
        endcase
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        bdot_lane u_lane (
            .ctl_i (ctl),
            .acc_i (acc_in[LANE_W*j +: LANE_W]),
            .a_i   (a_in[LANE_W*j +: LANE_W]),
            .b_i   (b_in[LANE_W*j +: LANE_W]),
            .y_o   (lane_res[LANE_W*j +: LANE_W])
        );
    end

    if (OUT_REG) begin : g_reg
        logic             vld_q;
        logic [VEC_W-1:0] res_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
                res_q <= '0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    res_q <= lane_res;
                end
            end
        end

        assign out_valid = vld_q;
        assign result    = MAX_W'(res_q);

        // R10
        vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        // R10
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> (!out_valid && $stable(result)));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = MAX_W'(lane_res);
    end

    if (MAX_W > VEC_W) begin : g_upper
        // R9
        upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
            result[MAX_W-1:VEC_W] == '0);
    end
endmodule

// File: tb/bdot_accum_tb.sv
module bdot_accum_tb;
    localparam int MAX_W = 256;
    localparam int VEC_W = 128;
    localparam int LANES = VEC_W / 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [2:0]       mode;
    logic [VEC_W-1:0] acc_in, a_in, b_in;
    logic             out_valid;
    logic [MAX_W-1:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10ns clk = ~clk;

    bdot_accum #(.MAX_W(MAX_W), .VEC_W(VEC_W), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .acc_in(acc_in), .a_in(a_in), .b_in(b_in),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] model_lane(input logic [2:0] m, input logic [31:0] acc,
                                               input logic [31:0] a, input logic [31:0] b);
        longint s;
        int av, bv;
        if (m[1:0] == 2'b11) return 32'h0;
        s = (m[1:0] == 2'b10) ? longint'({32'b0, acc}) : longint'($signed(acc));
        for (int k = 0; k < 4; k++) begin
            av = (m[1:0] != 2'b10) ? int'($signed(a[8*k +: 8])) : int'(a[8*k +: 8]);
            bv = (m[1:0] == 2'b00) ? int'($signed(b[8*k +: 8])) : int'(b[8*k +: 8]);
            s += longint'(av * bv);
        end
        if (m[2]) begin
            if (m[1:0] == 2'b10) begin
                if (s > 64'sh0FFFF_FFFF) s = 64'sh0FFFF_FFFF;
            end else begin
                if (s > 64'sd2147483647) s = 64'sd2147483647;
                if (s < -64'sd2147483648) s = -64'sd2147483648;
            end
        end
        return s[31:0];
    endfunction

    function automatic logic [MAX_W-1:0] model_vec(input logic [2:0] m, input logic [VEC_W-1:0] acc,
                                                   input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
        logic [MAX_W-1:0] v = '0;
        for (int j = 0; j < LANES; j++)
            v[32*j +: 32] = model_lane(m, acc[32*j +: 32], a[32*j +: 32], b[32*j +: 32]);
        return v;
    endfunction

    task automatic run_op(input string req, input logic [2:0] m, input logic [VEC_W-1:0] acc,
                          input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
        logic [MAX_W-1:0] exp_v;
        @(negedge clk);
        mode = m; acc_in = acc; a_in = a; b_in = b; in_valid = 1'b1;
        exp_v = model_vec(m, acc, a, b);
        @(negedge clk);
        in_valid = 1'b0;
        total++;
        if (result !== exp_v || out_valid !== 1'b1) begin
            bad++;
            $display("FAIL %s mode=%0d got=%h vld=%b exp=%h vld=1", req, m, result, out_valid, exp_v);
        end
    endtask

    function automatic logic [VEC_W-1:0] rep(input logic [31:0] w);
        logic [VEC_W-1:0] v;
        for (int j = 0; j < LANES; j++) v[32*j +: 32] = w;
        return v;
    endfunction

    initial begin
        logic [MAX_W-1:0] held;
        rst = 1'b1; in_valid = 1'b0; mode = '0; acc_in = '0; a_in = '0; b_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        total++;
        if (out_valid !== 1'b0 || result !== '0) begin
            bad++;
            $display("FAIL R10 reset got vld=%b res=%h exp vld=0 res=0", out_valid, result);
        end
        // R1: distinct lanes and byte positions
        run_op("R1", 3'b000, {32'd1000, 32'd2000, 32'd3000, 32'd4000},
               {32'h01020304, 32'h05060708, 32'h090A0B0C, 32'h0D0E0F10},
               {32'h11121314, 32'h15161718, 32'h191A1B1C, 32'h1D1E1F20});
        // R2: -128 x -128 in all pairs
        run_op("R2", 3'b000, rep(32'd0), rep(32'h80808080), rep(32'h80808080));
        run_op("R2", 3'b100, rep(32'hFFFFFFF0), rep(32'hFF7F80FE), rep(32'h80FF7F02));
        // R3: signed x unsigned
        run_op("R3", 3'b001, rep(32'd5), rep(32'hFFFFFFFF), rep(32'hFFFFFFFF));
        run_op("R3", 3'b101, rep(32'h80000010), rep(32'h80808080), rep(32'hFFFFFFFF));
        // R4 / R5: unsigned, max accumulator, wrap
        run_op("R4", 3'b010, rep(32'hFFFFFFFF), rep(32'hFFFFFFFF), rep(32'hFFFFFFFF));
        run_op("R5", 3'b000, rep(32'h7FFFFFF0), rep(32'h80808080), rep(32'h80808080));
        // R7: unsigned clamp
        run_op("R7", 3'b110, rep(32'hFFFFFFFF), rep(32'hFFFFFFFF), rep(32'hFFFFFFFF));
        run_op("R7", 3'b110, rep(32'h80000000), rep(32'h01010101), rep(32'h02020202));
        // R6: signed clamp both directions
        run_op("R6", 3'b100, rep(32'h7FFFFFF0), rep(32'h80808080), rep(32'h80808080));
        run_op("R6", 3'b100, rep(32'h80000010), rep(32'h80808080), rep(32'h7F7F7F7F));
        // R8: reserved encodings
        run_op("R8", 3'b011, rep(32'h12345678), rep(32'h01020304), rep(32'h05060708));
        run_op("R8", 3'b111, rep(32'h12345678), rep(32'h01020304), rep(32'h05060708));
        // R10: hold when idle
        held = result;
        @(negedge clk);
        mode = 3'b000; acc_in = rep(32'hDEADBEEF); a_in = rep(32'h7F7F7F7F); b_in = rep(32'h7F7F7F7F);
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || result !== held) begin
            bad++;
            $display("FAIL R10 hold got vld=%b res=%h exp vld=0 res=%h", out_valid, result, held);
        end
        // R9 + sweep of all modes
        for (int i = 0; i < 48; i++) begin
            logic [VEC_W-1:0] ra, rb, rc;
            for (int j = 0; j < LANES; j++) begin
                ra[32*j +: 32] = $urandom; rb[32*j +: 32] = $urandom; rc[32*j +: 32] = $urandom;
            end
            run_op("R9", 3'(i % 8), rc, ra, rb);
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not complete");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule